// File: doc/BRIEF.md
# Indexed-Enable Multi-CPU Interrupt Distributor

This block collects a set of level-sensitive interrupt sources and presents each of up to four CPUs with a single interrupt request line. Software never edits bitmaps. To change the global enable or a per-CPU mask, it writes the index of one interrupt to a dedicated set or clear register, and only that interrupt changes. A per-source control register holds a routing field with one bit per CPU. Each CPU reads an acknowledge register that returns the lowest-numbered interrupt it should service, or 1023 when nothing is pending for it.

A small set of sources, chosen by a parameter, is private to each CPU. These ignore the global enable and the routing field, and only the mask of the reading CPU gates them. Register accesses use a single-cycle valid/write/address/data port. A CPU-select input picks which CPU's banked mask and acknowledge registers an access reaches. Read data returns one cycle after the request.

Top module: `intd_dist`

## Requirements
- R1: A read at offset 0x00 returns the number of implemented sources in bits [11:2], with all other bits zero.
- R2: A write to offset 0x30 sets the global enable of the source whose index is in write data bits [9:0]. A write to offset 0x34 clears it. No other source changes.
- R3: A write to offset 0x48 masks the indexed source (write data [9:0]) for the CPU named on the CPU-select input. A write to offset 0x4C unmasks it. Other CPUs are not affected.
- R4: The control register of source n is at offset 0x100 + 4*n. Bit c of its routing field (bits [NUM_CPU-1:0]) routes the source to CPU c. The register reads back with all other bits zero.
- R5: A shared source reaches CPU c only when its input is high, it is globally enabled, its routing bit c is set, and CPU c has it unmasked.
- R6: Private sources (parameter map, default indexes 3 and 5) reach CPU c when their input is high and CPU c has them unmasked, whatever their enable and routing.
- R7: A read at offset 0x44 returns, in bits [9:0], the lowest index that reaches the selected CPU, or 1023 when none does. The upper bits are zero. Reading has no side effect, and a source stays pending while its input is high.
- R8: Output irq_o[c] is high exactly when CPU c's acknowledge value would be below 1023. It is registered, so it reflects the inputs and state sampled at the previous clock edge.
- R9: Reset clears every global enable, masks every source on every CPU, clears every routing field, and drives irq_o and read-valid low.
- R10: Index writes (0x30, 0x34, 0x48, 0x4C) whose index is at or above the number of sources change nothing.
- R11: A read request gives bus_rvalid high with its data on the next cycle. Write-only and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt source lines |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | CPU whose banked registers the access reaches |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | DATA_W | Read data |
| irq_o | output | NUM_CPU | Interrupt request per CPU |

## Verification
A write changes the enable, mask or routing state at the clock edge where it is sampled, so its effect first shows one cycle later, in irq_o and in read data. irq_o is registered. Its value after edge k is set by the source levels and the state as they stood just before edge k. Read data after edge k uses that same pre-edge state, so an acknowledge read and irq_o for the same CPU always agree in that cycle. The bench reference model follows this schedule. At each rising edge it first computes the expected outputs from its pre-edge state and then applies the write. The comparison runs at the next falling edge.

// File: rtl/intd_pkg.sv
// Shared constants and types for the indexed-enable interrupt distributor.
// Assumes byte offsets within a 12-bit register window.
package intd_pkg;
    localparam int IDX_W      = 10;
    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_EN_SET = 'h030;
    localparam int OFF_EN_CLR = 'h034;
    localparam int OFF_ACK    = 'h044;
    localparam int OFF_MK_SET = 'h048;
    localparam int OFF_MK_CLR = 'h04C;
    localparam int ROUTE_BASE = 'h100;
    localparam logic [IDX_W-1:0] ACK_NONE = 10'd1023;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_EN,
        OP_CLR_EN,
        OP_SET_MSK,
        OP_CLR_MSK,
        OP_ROUTE
    } intd_op_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_CTRL,
        RD_ACK,
        RD_ROUTE
    } intd_rd_e;
endpackage

// File: rtl/intd_decode.sv
// Register access decoder. Turns one bus request into a state operation
// (with a target index and whether that index exists) or a read selector.
// Assumes NUM_SRC <= 64 so the routing window fits below offset 0x200.
module intd_decode
    import intd_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 12,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [IDX_W-1:0]  idx_i,
    output intd_op_e          op_o,
    output logic [IDX_W-1:0]  tgt_o,
    output logic              tgt_ok_o,
    output intd_rd_e          rd_sel_o,
    output logic [SRC_W-1:0]  rd_idx_o
);
    logic              in_route;
    logic [ADDR_W-1:0] route_off;

    // Locate accesses that fall inside the per-source routing window
    always_comb begin
        route_off = bus_addr - ADDR_W'(ROUTE_BASE);
        in_route  = (bus_addr >= ADDR_W'(ROUTE_BASE)) &&
                    (bus_addr <  ADDR_W'(ROUTE_BASE + 4 * NUM_SRC)) &&
                    (bus_addr[1:0] == 2'b00);
    end

    // Classify the request into one operation or one read source
    always_comb begin
        op_o     = OP_NONE;
        tgt_o    = idx_i;
        rd_sel_o = RD_ZERO;
        rd_idx_o = SRC_W'(route_off >> 2);
        if (bus_valid && bus_write) begin
            case (bus_addr)
                ADDR_W'(OFF_EN_SET): op_o = OP_SET_EN;
                ADDR_W'(OFF_EN_CLR): op_o = OP_CLR_EN;
                ADDR_W'(OFF_MK_SET): op_o = OP_SET_MSK;
                ADDR_W'(OFF_MK_CLR): op_o = OP_CLR_MSK;
                default: begin
                    if (in_route) begin
                        op_o  = OP_ROUTE;
                        tgt_o = IDX_W'(route_off >> 2);
                    end
                end
            endcase
        end else if (bus_valid) begin
            if (bus_addr == ADDR_W'(OFF_CTRL))     rd_sel_o = RD_CTRL;
            else if (bus_addr == ADDR_W'(OFF_ACK)) rd_sel_o = RD_ACK;
            else if (in_route)                     rd_sel_o = RD_ROUTE;
        end
    end

    // Indexes beyond the implemented range must not touch any state
    assign tgt_ok_o = (tgt_o < IDX_W'(NUM_SRC));
endmodule

// File: rtl/intd_state.sv
// Enable, mask and routing storage. Each bit changes only when an
// operation names its own index, so there is no read-modify-write.
// Assumes op/tgt come from intd_decode in the same cycle.
module intd_state
    import intd_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  intd_op_e                          op_i,
    input  logic [IDX_W-1:0]                  tgt_i,
    input  logic                              tgt_ok_i,
    input  logic [CPU_W-1:0]                  cpu_i,
    input  logic [NUM_CPU-1:0]                route_data_i,
    output logic [NUM_SRC-1:0]                en_o,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_o,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic hit;
        assign hit = tgt_ok_i && (tgt_i == IDX_W'(s));

        // Global enable bit of source s
        always_ff @(posedge clk) begin
            if (!rst_n)                          en_o[s] <= 1'b0;
            else if (hit && op_i == OP_SET_EN)   en_o[s] <= 1'b1;
            else if (hit && op_i == OP_CLR_EN)   en_o[s] <= 1'b0;
        end

        // Routing field of source s
        always_ff @(posedge clk) begin
            if (!rst_n)                        route_o[s] <= '0;
            else if (hit && op_i == OP_ROUTE)  route_o[s] <= route_data_i;
        end

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic mine;
            assign mine = hit && (cpu_i == CPU_W'(c));

            // Mask bit of source s as seen by CPU c
            always_ff @(posedge clk) begin
                if (!rst_n)                           mask_o[c][s] <= 1'b1;
                else if (mine && op_i == OP_SET_MSK)  mask_o[c][s] <= 1'b1;
                else if (mine && op_i == OP_CLR_MSK)  mask_o[c][s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/intd_pick.sv
// Lowest-index finder: reports whether any request bit is set and the
// position of the lowest one. Purely combinational.
module intd_pick #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 10
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan downward so the lowest set bit is written last and wins
    always_comb begin
        hit_o = |req_i;
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/intd_dist.sv
// Indexed-enable multi-CPU interrupt distributor (top).
// Combines source levels with enable, routing and per-CPU masks,
// picks the lowest deliverable index per CPU, and registers irq_o and
// read data. Assumes NUM_SRC <= 64, NUM_CPU <= 4, synchronous reset.
module intd_dist
    import intd_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter logic [NUM_SRC-1:0] PRIVATE_MAP = NUM_SRC'(40),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_rvalid,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CPU-1:0] irq_o
);
    intd_op_e                            op;
    logic [IDX_W-1:0]                    tgt;
    logic                                tgt_ok;
    intd_rd_e                            rd_sel;
    logic [SRC_W-1:0]                    rd_idx;
    logic [NUM_SRC-1:0]                  en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]     mask_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]     route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]     route_col;
    logic [NUM_CPU-1:0]                  hit;
    logic [NUM_CPU-1:0][IDX_W-1:0]       pick_idx;
    logic [NUM_CPU-1:0][IDX_W-1:0]       ack_val;
    logic [DATA_W-1:0]                   rd_next;
    logic                                unused_wdata;

    assign unused_wdata = ^bus_wdata;

    intd_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .idx_i     (bus_wdata[IDX_W-1:0]),
        .op_o      (op),
        .tgt_o     (tgt),
        .tgt_ok_o  (tgt_ok),
        .rd_sel_o  (rd_sel),
        .rd_idx_o  (rd_idx)
    );

    intd_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .tgt_i        (tgt),
        .tgt_ok_i     (tgt_ok),
        .cpu_i        (bus_cpu),
        .route_data_i (bus_wdata[NUM_CPU-1:0]),
        .en_o         (en_q),
        .mask_o       (mask_q),
        .route_o      (route_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] live;

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
            assign route_col[c][s] = route_q[s][c];
        end

        // Private sources bypass enable and routing; all obey this CPU's mask
        assign live = src_i & ~mask_q[c] & (PRIVATE_MAP | (en_q & route_col[c]));

        intd_pick #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_pick (
            .req_i (live),
            .hit_o (hit[c]),
            .idx_o (pick_idx[c])
        );

        assign ack_val[c] = hit[c] ? pick_idx[c] : ACK_NONE;
    end

    // Select the value returned for the current read request
    always_comb begin
        case (rd_sel)
            RD_CTRL:  rd_next = DATA_W'(NUM_SRC) << 2;
            RD_ACK:   rd_next = DATA_W'(ack_val[bus_cpu]);
            RD_ROUTE: rd_next = DATA_W'(route_q[rd_idx]);
            default:  rd_next = '0;
        endcase
    end

    // Register read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            bus_rdata  <= rd_next;
        end
    end

    // Register per-CPU interrupt request lines
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= '0;
        else        irq_o <= hit;
    end
endmodule

// File: rtl/intd_dist_checker.sv
// Port-level properties of intd_dist, attached by bind below.
module intd_dist_checker #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [CPU_W-1:0]   bus_cpu,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rvalid,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_CPU-1:0] irq_o
);
    logic is_rd;
    logic is_ack;
    assign is_rd  = bus_valid && !bus_write;
    assign is_ack = is_rd && (bus_addr == ADDR_W'('h44));

    p_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && bus_addr == '0) |=> (bus_rdata == (DATA_W'(NUM_SRC) << 2)));

    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> (irq_o == '0));

    p_ackfmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> (bus_rdata[DATA_W-1:10] == '0 &&
                    (bus_rdata[9:0] == 10'd1023 || bus_rdata[9:0] < 10'(NUM_SRC))));

    p_ack_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> ((bus_rdata[9:0] != 10'd1023) == irq_o[$past(bus_cpu)]));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0 && !bus_rvalid));

    p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> bus_rvalid);

    p_norv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !bus_rvalid);
endmodule

bind intd_dist intd_dist_checker #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/intd_dist_test.sv
`timescale 1ns/1ps
module intd_dist_test;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam bit [NS-1:0] PRIV = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_cpu = '0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_o;

    always #2 clk = ~clk;

    intd_dist uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    // Behavioural reference state
    bit            m_en   [NS];
    bit            m_msk  [NC][NS];
    bit [NC-1:0]   m_rt   [NS];
    logic [NC-1:0] exp_irq;
    logic          exp_rv;
    logic [31:0]   exp_rd;
    bit            armed = 0;
    int            n_vec = 0;
    int            n_bad = 0;
    string         tag = "R9";

    function automatic int model_ack(int c);
        for (int s = 0; s < NS; s++)
            if (src_i[s] && !m_msk[c][s] && (PRIV[s] || (m_en[s] && m_rt[s][c])))
                return s;
        return 1023;
    endfunction

    function automatic bit in_route(int a);
        return a >= 'h100 && a < 'h100 + 4 * NS && (a % 4) == 0;
    endfunction

    function automatic logic [31:0] model_read(int c, int a);
        if (a == 0) return 32'(NS << 2);
        if (a == 'h44) return 32'(model_ack(c));
        if (in_route(a)) return 32'(m_rt[(a - 'h100) / 4]);
        return 32'd0;
    endfunction

    // Expected outputs from pre-edge state, then apply the write
    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin
                m_en[s] = 0; m_rt[s] = '0;
                for (int c = 0; c < NC; c++) m_msk[c][s] = 1;
            end
            exp_irq = '0; exp_rv = 0; exp_rd = '0;
        end else begin
            int a, idx, c;
            a = int'(bus_addr); c = int'(bus_cpu); idx = int'(bus_wdata[9:0]);
            for (int k = 0; k < NC; k++) exp_irq[k] = (model_ack(k) != 1023);
            exp_rv = bus_valid && !bus_write;
            if (exp_rv) exp_rd = model_read(c, a);
            if (bus_valid && bus_write) begin
                if (a == 'h30 && idx < NS) m_en[idx] = 1;
                else if (a == 'h34 && idx < NS) m_en[idx] = 0;
                else if (a == 'h48 && idx < NS) m_msk[c][idx] = 1;
                else if (a == 'h4C && idx < NS) m_msk[c][idx] = 0;
                else if (in_route(a)) m_rt[(a - 'h100) / 4] = bus_wdata[NC-1:0];
            end
        end
    end

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (armed) begin
            n_vec++;
            if (irq_o !== exp_irq) begin
                n_bad++;
                $display("FAIL %s irq_o actual=%b expected=%b t=%0t", tag, irq_o, exp_irq, $time);
            end
            n_vec++;
            if (bus_rvalid !== exp_rv) begin
                n_bad++;
                $display("FAIL R11 rvalid actual=%b expected=%b t=%0t", bus_rvalid, exp_rv, $time);
            end
            if (exp_rv) begin
                n_vec++;
                if (bus_rdata !== exp_rd) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, bus_rdata, exp_rd, $time);
                end
            end
        end
    end

    task automatic wr(int c, int a, int d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_cpu = 2'(c); bus_addr = 12'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(int c, int a);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_cpu = 2'(c); bus_addr = 12'(a);
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic rd_acks();
        for (int c = 0; c < NC; c++) rd(c, 'h44);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state, sources active but everything masked
        src_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R9"; rd_acks(); rd(0, 'h100); rd(3, 'h17C);
        tag = "R1"; rd(2, 'h000);
        tag = "R11"; rd(0, 'h030); rd(1, 'h048); rd(0, 'h0FC); rd(0, 'h101);
        src_i = '0;
        // R2 and R4: enable, route and unmask source 7 for CPU 0
        tag = "R4"; wr(0, 'h100 + 4*7, 32'hFFFF_FFF1); rd(0, 'h100 + 4*7);
        tag = "R2"; wr(0, 'h30, 7); wr(0, 'h4C, 7); src_i[7] = 1;
        repeat (2) @(negedge clk); rd_acks();
        wr(0, 'h34, 7); rd_acks();
        wr(0, 'h30, 32'hABCD_0007); rd_acks();
        // R3: source 9 routed to CPUs 0,1; mask only on CPU 1
        tag = "R3"; wr(0, 'h100 + 4*9, 3); wr(0, 'h30, 9); wr(0, 'h4C, 9); wr(1, 'h4C, 9);
        src_i[9] = 1; rd_acks(); wr(1, 'h48, 9); rd_acks(); src_i[7] = 0; rd_acks();
        // R5: routed to CPU 2, unmasked only on CPU 3
        tag = "R5"; wr(0, 'h100 + 4*12, 4); wr(0, 'h30, 12); wr(3, 'h4C, 12); src_i[12] = 1;
        rd_acks(); wr(2, 'h4C, 12); rd_acks(); src_i[12] = 0; rd_acks();
        // R6: private sources 3 and 5, no enable, no route
        tag = "R6"; src_i[5] = 1; src_i[3] = 1; rd_acks(); wr(2, 'h4C, 5); rd_acks();
        wr(2, 'h4C, 3); rd_acks(); wr(0, 'h34, 3); wr(0, 'h100 + 4*3, 0); rd_acks();
        // R7: several pending on CPU 0; lowest wins, reads are repeatable
        tag = "R7"; src_i[7] = 1; wr(0, 'h4C, 5); wr(0, 'h4C, 3);
        rd(0, 'h44); rd(0, 'h44); src_i[3] = 0; rd(0, 'h44); src_i[5] = 0; rd(0, 'h44);
        src_i[9] = 0; src_i[7] = 0; rd(0, 'h44); rd(2, 'h44);
        // R8: irq follows sources while bus idle
        tag = "R8"; src_i[9] = 1; repeat (3) @(negedge clk); src_i[9] = 0; repeat (3) @(negedge clk);
        // R10: out-of-range indexes
        tag = "R10"; src_i = '1;
        wr(0, 'h30, 32); wr(1, 'h4C, 40); wr(2, 'h4C, 1023); wr(0, 'h34, 32 + 9);
        wr(3, 'h48, 32 + 5); rd_acks(); rd(0, 'h17C);
        // Random mixed traffic against the model
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            int r, c, ix;
            @(negedge clk);
            if ($urandom % 4 == 0) src_i = $urandom;
            r = $urandom % 9; c = $urandom % NC; ix = $urandom % 36;
            bus_cpu = 2'(c); bus_wdata = $urandom & 32'hFFFF_FC00 | 32'(ix);
            bus_valid = (r < 8); bus_write = (r < 5);
            case (r)
                0: bus_addr = 'h30;
                1: bus_addr = 'h34;
                2: bus_addr = 'h48;
                3: bus_addr = 'h4C;
                4: bus_addr = 12'('h100 + 4 * ($urandom % 34));
                5: bus_addr = 'h44;
                6: bus_addr = 12'('h100 + 4 * ($urandom % 34));
                default: bus_addr = 12'($urandom % 'h200);
            endcase
        end
        @(negedge clk); bus_valid = 0;
        // R9: reset in the middle of traffic
        tag = "R9"; rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; rd_acks();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule